// File: doc/BRIEF.md
# Four-Way Address Strap Classifier

This block works out how each of two address strap pins is wired: to ground, to the supply, to the bus data line or to the bus clock line. A strap that is held at a fixed level can be read at any time. A strap tied to one of the bus lines can only be recognised while the bus is active. The block therefore watches every bus transaction and compares each strap's sampled level with the sampled SCL and SDA levels. It starts collecting this evidence at a START condition and stops at the end of the first byte. It does this for every transaction, whether or not that transaction is meant for this device, so the address can be rewired without a power cycle.

Each strap gets a 2-bit class. The two classes together form a 4-bit address nibble. A sticky flag shows that at least one full classification has been committed. Before the first transaction both bus lines idle high, so a strap wired to a bus line reads as tied to the supply. Until the first commit, the classes therefore only hold the two fixed-level values. These are also the values that pick the power-up defaults of the outputs elsewhere in the device.

All inputs arrive already synchronized to `clk`. Protocol handling beyond START and STOP detection and bit counting belongs to other blocks.

Top module: `strap_classifier`

## Requirements
- R1: Class codes are ground = 2'b00, supply = 2'b01, tied to SDA = 2'b10, tied to SCL = 2'b11. `addr_nibble[3:2]` is the class of `strap_hi` and `addr_nibble[1:0]` is the class of `strap_lo`.
- R2: While `rst_n` is low, both classes, `addr_nibble` and `classified` are all zero.
- R3: On the first clock edge after reset is released, each class is loaded as 2'b01 if its strap samples high and as 2'b00 if it samples low. On an idle bus, straps wired to SDA or SCL therefore read 2'b01. Until the first commit, neither class has its upper bit set and `classified` stays 0.
- R4: A START is SDA sampled falling while SCL is sampled high in two consecutive cycles. It opens a fresh evidence window. A repeated START discards the evidence gathered so far and restarts the bit count from zero.
- R5: A strap that equals SDA in every sampled cycle of the window, but differs from SCL in at least one, is classed 2'b10. A strap that equals SCL in every sampled cycle, but differs from SDA in at least one, is classed 2'b11. Any other strap is classed 2'b01 if it was high in every cycle and 2'b00 otherwise.
- R6: The new classes are committed on the clock edge that samples the eighth SCL rise after the START. `classified` is set on that edge and never clears until reset. Outside the first cycle after reset and commit edges, the classes do not change.
- R7: A STOP (SDA rising while SCL is high) before the eighth SCL rise closes the window and leaves the classes unchanged.
- R8: After a commit, further SCL edges have no effect on the classes until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Synchronized bus clock level |
| sda | input | 1 | Synchronized bus data level |
| strap_lo | input | 1 | Synchronized level of the low-half strap pin |
| strap_hi | input | 1 | Synchronized level of the high-half strap pin |
| class_lo | output | 2 | Class of the low-half strap |
| class_hi | output | 2 | Class of the high-half strap |
| addr_nibble | output | 4 | {class_hi, class_lo} |
| classified | output | 1 | Set once a full classification has been committed |

## Verification
Wrong evidence flags or a miscounted bit show up at the ports as a wrong nibble, or as a nibble committed one SCL rise early or late. The bench therefore compares the nibble just before and just after the eighth rise of every address byte. A stuck window shows up on the following byte or transaction, when a data byte, an aborted transaction or a repeated START wrongly changes or freezes the nibble. All sixteen strap wirings are swept under two address patterns, so a swapped code or a swapped half fails within the first few transactions.

// File: rtl/strap_classifier.sv
module strap_classifier #(
  parameter int ADDR_BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl,
  input  logic       sda,
  input  logic       strap_lo,
  input  logic       strap_hi,
  output logic [1:0] class_lo,
  output logic [1:0] class_hi,
  output logic [3:0] addr_nibble,
  output logic       classified
);
  localparam int CW = $clog2(ADDR_BITS + 1);

  logic          scl_q, sda_q, primed, active;
  logic [CW-1:0] nbits;
  logic [1:0]    m_sda, m_scl, all_hi;

  wire [1:0] pins     = {strap_hi, strap_lo};
  wire       start_ev = scl & scl_q & sda_q & ~sda;
  wire       stop_ev  = scl & scl_q & ~sda_q & sda;
  wire       rise_ev  = scl & ~scl_q;
  wire [1:0] now_sda  = m_sda & ~(pins ^ {2{sda}});
  wire [1:0] now_scl  = m_scl & ~(pins ^ {2{scl}});
  wire [1:0] now_hi   = all_hi & pins;
  wire       last_bit = active & rise_ev & (nbits == CW'(ADDR_BITS - 1));

  function automatic logic [1:0] code(input logic eqd, input logic eqc, input logic hi);
    if (eqd && !eqc)      code = 2'b10;
    else if (eqc && !eqd) code = 2'b11;
    else                  code = {1'b0, hi};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      primed     <= 1'b0;
      active     <= 1'b0;
      nbits      <= '0;
      m_sda      <= '0;
      m_scl      <= '0;
      all_hi     <= '0;
      class_lo   <= 2'b00;
      class_hi   <= 2'b00;
      classified <= 1'b0;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      if (!primed) begin
        primed   <= 1'b1;
        class_lo <= {1'b0, strap_lo};
        class_hi <= {1'b0, strap_hi};
      end
      if (start_ev) begin
        active <= 1'b1;
        nbits  <= '0;
        m_sda  <= ~(pins ^ {2{sda}});
        m_scl  <= ~(pins ^ {2{scl}});
        all_hi <= pins;
      end else if (active) begin
        if (stop_ev) begin
          active <= 1'b0;
        end else begin
          m_sda  <= now_sda;
          m_scl  <= now_scl;
          all_hi <= now_hi;
          if (rise_ev) nbits <= nbits + CW'(1);
          if (last_bit) begin
            active     <= 1'b0;
            class_lo   <= code(now_sda[0], now_scl[0], now_hi[0]);
            class_hi   <= code(now_sda[1], now_scl[1], now_hi[1]);
            classified <= 1'b1;
          end
        end
      end
    end
  end

  assign addr_nibble = {class_hi, class_lo};
endmodule

module strap_classifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl,
  input logic [1:0] class_lo,
  input logic [1:0] class_hi,
  input logic [3:0] addr_nibble,
  input logic       classified
);
  logic       sclq, rise_q;
  logic [1:0] warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclq   <= 1'b1;
      rise_q <= 1'b0;
      warm   <= 2'd0;
    end else begin
      sclq   <= scl;
      rise_q <= scl & ~sclq;
      if (warm != 2'd2) warm <= warm + 2'd1;
    end
  end

  a_r3_plain_before_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !classified |-> (!class_lo[1] && !class_hi[1]));

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    classified |=> classified);

  a_r6_flag_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(classified) |-> rise_q);

  a_r6_stable_without_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2 && !(scl && !sclq)) |=> $stable(addr_nibble));
endmodule

bind strap_classifier strap_classifier_chk i_chk (
  .clk(clk), .rst_n(rst_n), .scl(scl), .class_lo(class_lo),
  .class_hi(class_hi), .addr_nibble(addr_nibble), .classified(classified)
);

// File: tb/test_strap_classifier.sv
module test_strap_classifier;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic [1:0] cfg_lo = 2'd2, cfg_hi = 2'd3;
  logic strap_lo, strap_hi;
  logic [1:0] class_lo, class_hi;
  logic [3:0] addr_nibble;
  logic classified;
  int checks = 0, fails = 0;
  logic [3:0] held;

  always #4 clk = ~clk;

  function automatic logic lvl(input logic [1:0] c, input logic d, input logic k);
    case (c)
      2'd0: lvl = 1'b0;
      2'd1: lvl = 1'b1;
      2'd2: lvl = d;
      default: lvl = k;
    endcase
  endfunction

  assign strap_lo = lvl(cfg_lo, sda, scl);
  assign strap_hi = lvl(cfg_hi, sda, scl);

  strap_classifier i_strap_classifier (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda),
    .strap_lo(strap_lo), .strap_hi(strap_hi),
    .class_lo(class_lo), .class_hi(class_hi),
    .addr_nibble(addr_nibble), .classified(classified)
  );

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_cond();
    if (!scl) begin sda = 1'b1; tick(); scl = 1'b1; tick(); end
    sda = 1'b1; tick(); tick();
    sda = 1'b0; tick(); tick();
    scl = 1'b0; tick();
  endtask

  task automatic stop_cond();
    sda = 1'b0; tick();
    scl = 1'b1; tick(); tick();
    sda = 1'b1; tick(); tick();
  endtask

  task automatic send_bit(input logic b);
    sda = b; tick();
    scl = 1'b1; tick(); tick();
    scl = 1'b0; tick();
  endtask

  task automatic send_addr(input logic [7:0] v, input logic [3:0] old_n, input logic [3:0] new_n);
    for (int i = 7; i > 0; i--) send_bit(v[i]);
    chk(addr_nibble == old_n, "R6 no commit before eighth rise", addr_nibble, old_n);
    sda = v[0]; tick();
    scl = 1'b1; tick();
    chk(addr_nibble == new_n, "R5 R1 nibble at eighth rise", addr_nibble, new_n);
    chk(classified == 1'b1, "R6 classified set", classified, 1);
    tick();
    scl = 1'b0; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    chk(addr_nibble == 4'h0 && classified == 1'b0, "R2 reset state", {classified, addr_nibble}, 0);
    rst_n = 1'b1;
    tick(); tick();
    chk(addr_nibble == 4'b0101, "R3 bus straps read as supply", addr_nibble, 5);
    chk(classified == 1'b0, "R3 flag clear before commit", classified, 0);
    rst_n = 1'b0; cfg_lo = 2'd0; cfg_hi = 2'd1; tick();
    rst_n = 1'b1; tick(); tick();
    chk(addr_nibble == 4'b0100, "R3 fixed levels after reset", addr_nibble, 4);
    held = 4'b0100;

    for (int h = 0; h < 4; h++)
      for (int l = 0; l < 4; l++)
        for (int p = 0; p < 2; p++) begin
          logic [3:0] exp_n;
          cfg_hi = 2'(h); cfg_lo = 2'(l);
          exp_n = 4'(h * 4 + l);
          start_cond();
          send_addr(p ? 8'hA5 : 8'h3C, held, exp_n);
          held = exp_n;
          send_bit(1'b0);
          for (int i = 0; i < 8; i++) send_bit(1'b0);
          chk(addr_nibble == held, "R8 data byte ignored", addr_nibble, held);
          stop_cond();
        end

    cfg_hi = 2'd1; cfg_lo = 2'd1;
    start_cond();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    stop_cond();
    chk(addr_nibble == held, "R7 stop aborts window", addr_nibble, held);

    cfg_hi = 2'd2; cfg_lo = 2'd0;
    start_cond();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    start_cond();
    for (int i = 0; i < 5; i++) send_bit(1'(i & 1));
    chk(addr_nibble == held, "R4 repeated start restarts count", addr_nibble, held);
    send_bit(1'b1); send_bit(1'b0);
    chk(addr_nibble == held, "R4 still seven bits after restart", addr_nibble, held);
    sda = 1'b1; tick();
    scl = 1'b1; tick();
    chk(addr_nibble == 4'b1000, "R4 commit at eighth rise after restart", addr_nibble, 8);
    tick(); scl = 1'b0; tick();
    cfg_hi = 2'd0; cfg_lo = 2'd1;
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    chk(addr_nibble == 4'b1000, "R8 straps rewired without start", addr_nibble, 8);
    stop_cond();
    tick();
    chk(class_hi == 2'b10 && class_lo == 2'b00, "R1 class ports match nibble", {class_hi, class_lo}, 8);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule